// File: doc/BRIEF.md
# Extended Parallel-Port Control Window with Test FIFO

This block is the extended register window of a parallel port. A host reaches it through a byte-wide access port with a 3-bit offset. Three registers are visible in the window:

- an extended control register that holds a 3-bit operating mode and a 2-bit FIFO status;
- a configuration byte;
- a shared location at offset 0.

The current mode is also driven out on a dedicated output, so that the rest of the port logic can follow it.

A two-entry, eight-bit FIFO sits behind offset 0. The FIFO is reachable only while the mode is FIFO test (mode 6). In that mode a write at offset 0 pushes a byte and a read at offset 0 pops one. In every other mode, offset 0 is an ordinary byte register and the FIFO is left untouched.

Any write that changes the mode discards the FIFO contents. A write that keeps the same mode leaves them in place.

A read returns its data in the same cycle that the read strobe is high. Any side effect of an access, such as a pop, a push or a register update, takes place at the clock edge that ends the access.

Top module: `ecpx_window`

## Requirements
- R1: After reset the mode is 0 (compatible), the mode output is 0, the control register at offset 2 reads 0x01, and both the configuration byte (offset 1) and the offset-0 byte register read 0x00.
- R2: A write at offset 2 replaces the mode with write bits 7:5; write bits 4:0 are ignored. Offset 2 reads {mode[2:0], 3'b000, st[1:0]}, where st is 01 when the FIFO is empty, 10 when it is full and 00 when it is partly filled. The mode output follows the stored mode one cycle after the write, and the mode does not change without a write at offset 2.
- R3: Offset 1 is a full 8-bit read/write configuration byte.
- R4: In any mode other than 6, offset 0 reads and writes a plain byte register, and the FIFO state stays unchanged.
- R5: A write at offset 2 whose mode field differs from the current mode empties the FIFO. A write that carries the same mode keeps the FIFO contents.
- R6: In mode 6 a write at offset 0 pushes a byte and a read at offset 0 returns and removes the oldest byte. The FIFO holds two bytes, and its storage positions wrap around, so that first-in first-out order holds across any number of passes.
- R7: A push into a full FIFO is dropped and changes nothing.
- R8: A pop from an empty FIFO returns 0xFF and leaves the FIFO empty.
- R9: Offsets 3 to 7 ignore writes and read 0xFF.
- R10: Read data is valid in the same cycle as the read strobe. The read data is 0x00 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 3 | Register offset within the window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational while a read is strobed |
| mode_o | output | 3 | Current operating mode |

## Verification
The hardest situation to reach is a FIFO whose positions have wrapped while it still holds data, followed by a rewrite of the mode field. To get there, the bench fills the FIFO, overfills it once, and drains it past empty. It then refills across the wrap boundary and rewrites the same mode, which must not discard anything. Finally it changes the mode, which must discard a pending byte. Reading the status field after each step shows the empty, partial and full encodings at every stage.

// File: rtl/ecpx_pkg.sv
package ecpx_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 3;
    localparam int MODE_W = 3;
    localparam int STAT_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMPAT  = 3'd0,
        MODE_BYTE    = 3'd1,
        MODE_PPFIFO  = 3'd2,
        MODE_ECPFIFO = 3'd3,
        MODE_EPP     = 3'd4,
        MODE_RSVD    = 3'd5,
        MODE_FTEST   = 3'd6,
        MODE_CONFIG  = 3'd7
    } ecp_mode_e;

    localparam logic [OFF_W-1:0] OFF_SHARED = 3'd0;
    localparam logic [OFF_W-1:0] OFF_CFGB   = 3'd1;
    localparam logic [OFF_W-1:0] OFF_ECR    = 3'd2;

    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef struct packed {
        logic              en;
        logic              wr;
        logic [OFF_W-1:0]  off;
        logic [BYTE_W-1:0] wdata;
    } host_acc_t;

    typedef struct packed {
        logic empty;
        logic full;
    } fifo_flags_t;

    // Status encoding: empty -> 01, full -> 10, partial -> 00
    function automatic logic [STAT_W-1:0] fifo_status(input fifo_flags_t f);
        logic [STAT_W-1:0] s;
        s = 2'b00;
        if (f.empty)
            s = 2'b01;
        else if (f.full)
            s = 2'b10;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] ecr_image(input ecp_mode_e m,
                                                    input fifo_flags_t f);
        return {m, 3'b000, fifo_status(f)};
    endfunction

endpackage

// File: rtl/ecpx_fifo.sv
module ecpx_fifo
    import ecpx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] head_o,
    output fifo_flags_t   flags_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          is_empty, is_full, do_push, do_pop;

    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == CMAX);
    assign do_push  = push_i && !is_full && !flush_i;
    assign do_pop   = pop_i && !is_empty && !flush_i;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (do_pop)
                rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (do_push && wptr_q == PW'(g))
                mem_q[g] <= wdata_i;
        end
    end

    assign head_o        = mem_q[rptr_q];
    assign flags_o.empty = is_empty;
    assign flags_o.full  = is_full;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CMAX); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> flags_o.empty && !flags_o.full); // R5
    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        push_i && !pop_i && !flush_i && flags_o.full |=> flags_o.full && $stable(wptr_q)); // R7
    AST_POP_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop_i && !push_i && flags_o.empty |=> flags_o.empty && $stable(rptr_q)); // R8

endmodule

// File: rtl/ecpx_ctrl.sv
module ecpx_ctrl
    import ecpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_acc_t         acc_i,
    output ecp_mode_e         mode_o,
    output logic [BYTE_W-1:0] cfgb_o,
    output logic [BYTE_W-1:0] shared_o,
    output logic              push_o,
    output logic              pop_o,
    output logic              flush_o,
    output logic              rd_o
);

    ecp_mode_e         mode_q;
    logic [BYTE_W-1:0] cfgb_q, shared_q;
    logic              wr_hit, rd_hit, at_shared, in_test;
    ecp_mode_e         new_mode;

    assign wr_hit    = acc_i.en && acc_i.wr;
    assign rd_hit    = acc_i.en && !acc_i.wr;
    assign at_shared = (acc_i.off == OFF_SHARED);
    assign in_test   = (mode_q == MODE_FTEST);
    assign new_mode  = ecp_mode_e'(acc_i.wdata[BYTE_W-1 -: MODE_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_COMPAT;
            cfgb_q   <= '0;
            shared_q <= '0;
        end else if (wr_hit) begin
            case (acc_i.off)
                OFF_SHARED: if (!in_test) shared_q <= acc_i.wdata;
                OFF_CFGB:   cfgb_q <= acc_i.wdata;
                OFF_ECR:    mode_q <= new_mode;
                default:    ;
            endcase
        end
    end

    assign push_o   = wr_hit && at_shared && in_test;
    assign pop_o    = rd_hit && at_shared && in_test;
    assign flush_o  = wr_hit && (acc_i.off == OFF_ECR) && (new_mode != mode_q);
    assign rd_o     = rd_hit;
    assign mode_o   = mode_q;
    assign cfgb_o   = cfgb_q;
    assign shared_o = shared_q;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && acc_i.off == OFF_ECR) |=> $stable(mode_q)); // R2
    AST_SHARED_HOLD_TEST: assert property (@(posedge clk) disable iff (rst)
        in_test |=> $stable(shared_q)); // R4

endmodule

// File: rtl/ecpx_rdmux.sv
module ecpx_rdmux
    import ecpx_pkg::*;
(
    input  logic              rd_i,
    input  logic [OFF_W-1:0]  off_i,
    input  ecp_mode_e         mode_i,
    input  fifo_flags_t       flags_i,
    input  logic [BYTE_W-1:0] head_i,
    input  logic [BYTE_W-1:0] cfgb_i,
    input  logic [BYTE_W-1:0] shared_i,
    output logic [BYTE_W-1:0] rdata_o
);

    logic [BYTE_W-1:0] fifo_view;

    assign fifo_view = flags_i.empty ? IDLE_BYTE : head_i;

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (off_i)
                OFF_SHARED: rdata_o = (mode_i == MODE_FTEST) ? fifo_view : shared_i;
                OFF_CFGB:   rdata_o = cfgb_i;
                OFF_ECR:    rdata_o = ecr_image(mode_i, flags_i);
                default:    rdata_o = IDLE_BYTE;
            endcase
        end
    end

endmodule

// File: rtl/ecpx_window.sv
module ecpx_window
    import ecpx_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [2:0]  acc_off,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  acc_rdata,
    output logic [2:0]  mode_o
);

    host_acc_t         acc;
    ecp_mode_e         mode;
    fifo_flags_t       flags;
    logic [BYTE_W-1:0] cfgb, shared, head;
    logic              push, pop, flush, rd;

    assign acc = '{en: acc_en, wr: acc_wr, off: acc_off, wdata: acc_wdata};

    ecpx_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .acc_i    (acc),
        .mode_o   (mode),
        .cfgb_o   (cfgb),
        .shared_o (shared),
        .push_o   (push),
        .pop_o    (pop),
        .flush_o  (flush),
        .rd_o     (rd)
    );

    ecpx_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (pop),
        .flush_i (flush),
        .wdata_i (acc_wdata),
        .head_o  (head),
        .flags_o (flags)
    );

    ecpx_rdmux u_rdmux (
        .rd_i     (rd),
        .off_i    (acc_off),
        .mode_i   (mode),
        .flags_i  (flags),
        .head_i   (head),
        .cfgb_i   (cfgb),
        .shared_i (shared),
        .rdata_o  (acc_rdata)
    );

    assign mode_o = mode;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> mode_o == 3'd0 && flags.empty); // R1
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags.empty && flags.full)); // R2
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> acc_rdata == 8'h00); // R10

endmodule

// File: tb/sim_ecpx_window.sv
module sim_ecpx_window;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_en, acc_wr;
    logic [2:0] acc_off;
    logic [7:0] acc_wdata;
    logic [7:0] acc_rdata;
    logic [2:0] mode_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ecpx_window u0 (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_off(acc_off), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .mode_o(mode_o)
    );

    // Entry: {req[3:0], wr, off[2:0], data[7:0]}; for reads data is the expected value
    localparam int NV = 40;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1, 1'b0, 3'd2, 8'h01},  // R1 control after reset
        {4'd1, 1'b0, 3'd1, 8'h00},  // R1 config byte
        {4'd1, 1'b0, 3'd0, 8'h00},  // R1 shared byte
        {4'd3, 1'b1, 3'd1, 8'hA5},
        {4'd3, 1'b0, 3'd1, 8'hA5},  // R3
        {4'd4, 1'b1, 3'd0, 8'h3C},
        {4'd4, 1'b0, 3'd0, 8'h3C},  // R4 plain register
        {4'd4, 1'b0, 3'd2, 8'h01},  // R4 FIFO untouched
        {4'd2, 1'b1, 3'd2, 8'hDF},  // mode 6, low bits ignored
        {4'd2, 1'b0, 3'd2, 8'hC1},  // R2
        {4'd6, 1'b1, 3'd0, 8'h11},
        {4'd2, 1'b0, 3'd2, 8'hC0},  // R2 partial
        {4'd6, 1'b1, 3'd0, 8'h22},
        {4'd2, 1'b0, 3'd2, 8'hC2},  // R2 full
        {4'd7, 1'b1, 3'd0, 8'h33},  // dropped
        {4'd7, 1'b0, 3'd2, 8'hC2},  // R7
        {4'd6, 1'b0, 3'd0, 8'h11},  // R6 order
        {4'd6, 1'b0, 3'd2, 8'hC0},
        {4'd6, 1'b0, 3'd0, 8'h22},
        {4'd6, 1'b0, 3'd2, 8'hC1},
        {4'd8, 1'b0, 3'd0, 8'hFF},  // R8
        {4'd8, 1'b0, 3'd2, 8'hC1},
        {4'd6, 1'b1, 3'd0, 8'h44},  // after wrap
        {4'd6, 1'b1, 3'd0, 8'h55},
        {4'd6, 1'b0, 3'd0, 8'h44},  // R6 wrap
        {4'd5, 1'b1, 3'd2, 8'hC0},  // same mode
        {4'd5, 1'b0, 3'd2, 8'hC0},  // R5 no flush
        {4'd5, 1'b0, 3'd0, 8'h55},
        {4'd5, 1'b1, 3'd0, 8'h66},
        {4'd5, 1'b1, 3'd2, 8'h40},  // to mode 2 -> flush
        {4'd5, 1'b0, 3'd2, 8'h41},  // R5
        {4'd4, 1'b0, 3'd0, 8'h3C},  // R4 shared retained
        {4'd5, 1'b1, 3'd2, 8'hC0},  // back to test, flush again
        {4'd5, 1'b0, 3'd0, 8'hFF},  // R5 byte 66 gone
        {4'd9, 1'b1, 3'd3, 8'h77},
        {4'd9, 1'b0, 3'd3, 8'hFF},  // R9
        {4'd9, 1'b1, 3'd7, 8'h12},
        {4'd9, 1'b0, 3'd7, 8'hFF},  // R9
        {4'd9, 1'b0, 3'd1, 8'hA5},  // R9 config untouched
        {4'd9, 1'b0, 3'd2, 8'hC1}   // R9 control untouched
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one access; a read is checked in its own cycle (R10)
    task automatic access(input logic wr, input logic [2:0] off, input logic [7:0] d,
                          input bit chk, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_off = off; acc_wdata = wr ? d : 8'h00;
        #1;
        if (!wr && chk) check(req, acc_rdata, d);
        @(posedge clk);
        #1;
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_en = 1'b0; acc_wr = 1'b0; acc_off = '0; acc_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 mode output", {5'd0, mode_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][11], VEC[i][10:8], VEC[i][7:0], 1'b1,
                   $sformatf("R%0d vector %0d", VEC[i][15:12], i));
        end

        // R10 idle read data
        @(negedge clk);
        check("R10 idle rdata", acc_rdata, 8'h00);

        // R2 each mode reaches the mode output
        for (int m = 0; m < 8; m++) begin
            access(1'b1, 3'd2, {m[2:0], 5'b10101}, 1'b0, "");
            @(negedge clk);
            check("R2 mode output", {5'd0, mode_o}, {5'd0, m[2:0]});
            access(1'b0, 3'd2, {m[2:0], 3'b000, 2'b01}, 1'b1, "R2 control readback");
        end

        // R4 shared byte in non-test modes keeps FIFO empty, then test mode sees empty
        access(1'b1, 3'd2, 8'h20, 1'b0, "");
        access(1'b1, 3'd0, 8'h9A, 1'b0, "");
        access(1'b0, 3'd0, 8'h9A, 1'b1, "R4 byte mode shared");
        access(1'b0, 3'd2, 8'h21, 1'b1, "R4 status still empty");

        // R1 reset mid-operation
        access(1'b1, 3'd2, 8'hC0, 1'b0, "");
        access(1'b1, 3'd0, 8'hE1, 1'b0, "");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        access(1'b0, 3'd2, 8'h01, 1'b1, "R1 control after second reset");
        access(1'b0, 3'd1, 8'h00, 1'b1, "R1 config after second reset");
        access(1'b0, 3'd0, 8'h00, 1'b1, "R1 shared after second reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule